// File: doc/BRIEF.md
# Instruction Queue with Replay

This block sits between the instruction realigner and the decoder of a processor front end. In each cycle it can take zero, one or two instructions from two input slots. It stores them in a small circular buffer and hands them to decode one at a time over a valid/ready handshake. Each stored entry holds the instruction word, its address, a control-flow kind, a predicted target address, a page-fault flag and the faulting address. All of these reach the decoder unchanged and in program order.

When an offered instruction finds no free entry, the queue does not stall the cache. It accepts what fits, drops the rest and raises a replay request. The request carries the address of the first instruction it dropped, and fetch restarts there. A per-slot accept vector tells the fetch logic which slots were taken. A flush empties the queue at once.

A fill-level state machine tracks occupancy and drives the decode-side valid and the cache-side ready. It has four states:
- EMPTY: no entries.
- ROOMY: some entries and at least two free.
- TIGHT: exactly one free entry.
- FULL: no free entry.

Its transitions are:
- fill: the net count rises.
- drain: the net count falls.
- hold: no net change.
- flush: every state returns to EMPTY.

Top module: `instr_queue_replay`

## Requirements
- R1: While reset is asserted, and after it is released with no traffic, `out_valid_o` is 0, `ready_o` is 1, `replay_o` is 0 and `consumed_o` is 2'b00. Reset is asynchronous and active low.
- R2: The queue holds at most DEPTH (default 4) entries. Once it holds 4, a further offered instruction is not accepted.
- R3: An entry leaves the queue in a cycle where both `out_valid_o` and `out_ready_i` are 1, at most one per cycle. Entries leave in arrival order. The instruction, address, control-flow kind and predicted target on the output equal the values given when the entry was written.
- R4: When both slots are valid and both are accepted, slot 0 (low bits of each two-slot input) is stored ahead of slot 1. If slot 1 is accepted, slot 0 was also accepted or was not valid.
- R5: When a valid slot is not accepted, `replay_o` is 1 in that same cycle and `replay_addr_o` is the address of the lowest-numbered valid slot not accepted. A valid slot after it in that cycle is also rejected.
- R6: Bit s of `consumed_o` is 1 exactly when slot s was valid and was written into the queue in that cycle.
- R7: `ready_o` is 1 exactly when at least two entries are free. While it is 1 and no flush is requested, every valid slot is accepted.
- R8: While `flush_i` is 1, no slot is accepted, `replay_o` is 0 and `out_valid_o` is 0. All stored entries are gone from the next cycle on.
- R9: Room is judged on the occupancy at the start of the cycle. A pop in the same cycle frees no room for that cycle's input. A push and a pop in one cycle are both carried out.
- R10: The page-fault flag and faulting address given with an accepted instruction appear on `out_ex_o` and `out_ex_addr_o` when that entry is at the head. They apply to every slot accepted in that cycle.
- R11: A lone valid slot 1 (slot 0 not valid) is accepted whenever one entry is free. It is stored at the next position in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all entries and reject this cycle's input |
| valid_i | input | 2 | Per-slot instruction valid |
| instr_i | input | 64 | Instruction words, slot 0 in bits 31:0 |
| addr_i | input | 64 | Instruction addresses, slot 0 in bits 31:0 |
| cf_type_i | input | 6 | Control-flow kind per slot, 3 bits each, slot 0 in bits 2:0 |
| predict_addr_i | input | 32 | Predicted target stored with accepted slots |
| exception_i | input | 1 | Page fault on this fetch |
| exception_addr_i | input | 32 | Faulting address |
| ready_o | output | 1 | At least two free entries |
| consumed_o | output | 2 | Per-slot accept |
| replay_o | output | 1 | Fetch must restart |
| replay_addr_o | output | 32 | Address at which fetch restarts |
| out_valid_o | output | 1 | Head entry is valid |
| out_ready_i | input | 1 | Decoder takes the head entry |
| out_instr_o | output | 32 | Head instruction |
| out_addr_o | output | 32 | Head address |
| out_cf_o | output | 3 | Head control-flow kind |
| out_pred_o | output | 32 | Head predicted target |
| out_ex_o | output | 1 | Head carries a page fault |
| out_ex_addr_o | output | 32 | Head faulting address |

## Verification
The properties assume that `valid_i`, `flush_i` and `out_ready_i` carry known values on every clock edge after reset is released. They also assume the decoder's ready does not depend on this cycle's input slots. The bench keeps to this by driving every input to a defined value on the falling edge, including idle cycles. It never leaves a control input undriven. Data fields on an invalid slot are still driven, with predictable values, so any leak of a dropped slot into the queue shows up as a wrong head entry.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int CF_W = 3;

    typedef enum logic [CF_W-1:0] {
        CF_NONE   = 3'd0,
        CF_BRANCH = 3'd1,
        CF_JUMP   = 3'd2,
        CF_JALR   = 3'd3,
        CF_RETURN = 3'd4
    } cf_kind_e;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_ROOMY,
        FILL_TIGHT,
        FILL_FULL
    } fill_state_e;
endpackage

// File: rtl/iq_slot_admit.sv
module iq_slot_admit #(
    parameter int NSLOT  = 2,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic                    flush_i,
    input  logic [NSLOT-1:0]        valid_i,
    input  logic [NSLOT*ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]        free_i,
    output logic [NSLOT-1:0]        accept_o,
    output logic                    replay_o,
    output logic [ADDR_W-1:0]       replay_addr_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Walk slots in program order; the first slot that finds no room
    // blocks itself and every later slot.
    always_comb begin
        logic             blocked;
        logic [CNT_W-1:0] taken;
        accept_o      = '0;
        replay_o      = 1'b0;
        replay_addr_o = '0;
        blocked       = flush_i;
        taken         = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (valid_i[s] && !blocked) begin
                if (free_i > taken) begin
                    accept_o[s] = 1'b1;
                    taken       = taken + ONE;
                end else begin
                    blocked       = 1'b1;
                    replay_o      = 1'b1;
                    replay_addr_o = addr_i[s*ADDR_W +: ADDR_W];
                end
            end
        end
    end
endmodule

// File: rtl/iq_fill_ctrl.sv
module iq_fill_ctrl
    import iq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NSLOT = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             flush_i,
    input  logic [CNT_W-1:0] push_cnt_i,
    input  logic             pop_i,
    output logic [CNT_W-1:0] free_o,
    output logic             occupied_o,
    output logic             pair_room_o,
    output fill_state_e      state_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TIGHT_C = CNT_W'(DEPTH - 1);

    fill_state_e      state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    // Next occupancy and the named transitions fill / drain / hold / flush.
    always_comb begin
        if (flush_i) begin
            count_d = '0;
        end else begin
            count_d = count_q + push_cnt_i - CNT_W'(pop_i);
        end
        if (count_d == '0) begin
            state_d = FILL_EMPTY;
        end else if (count_d == DEPTH_C) begin
            state_d = FILL_FULL;
        end else if (count_d == TIGHT_C) begin
            state_d = FILL_TIGHT;
        end else begin
            state_d = FILL_ROOMY;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FILL_EMPTY;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        unique case (state_q)
            FILL_EMPTY: begin
                occupied_o  = 1'b0;
                pair_room_o = 1'b1;
            end
            FILL_ROOMY: begin
                occupied_o  = 1'b1;
                pair_room_o = 1'b1;
            end
            FILL_TIGHT: begin
                occupied_o  = 1'b1;
                pair_room_o = 1'b0;
            end
            FILL_FULL: begin
                occupied_o  = 1'b1;
                pair_room_o = 1'b0;
            end
            default: begin
                occupied_o  = 1'b0;
                pair_room_o = 1'b0;
            end
        endcase
    end

    assign free_o  = DEPTH_C - count_q;
    assign state_o = state_q;

    p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q <= DEPTH_C);

    p_full_no_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FILL_FULL) |-> (free_o == '0));

    p_flush_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (state_q == FILL_EMPTY));

    p_no_pop_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FILL_EMPTY) |-> !pop_i);
endmodule

// File: rtl/iq_ring.sv
module iq_ring #(
    parameter int DEPTH = 4,
    parameter int NSLOT = 2,
    parameter int ENT_W = 64,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   flush_i,
    input  logic [NSLOT-1:0]       we_i,
    input  logic [NSLOT*ENT_W-1:0] wdata_i,
    input  logic                   pop_i,
    output logic [ENT_W-1:0]       rdata_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [ENT_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_adv;
    logic [PTR_W-1:0] slot_idx [NSLOT];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // Accepted slots take consecutive positions, lower slot first.
    always_comb begin
        logic [PTR_W-1:0] cur;
        cur = wr_ptr_q;
        for (int s = 0; s < NSLOT; s++) begin
            slot_idx[s] = cur;
            if (we_i[s]) begin
                cur = bump(cur);
            end
        end
        wr_adv = cur;
    end

    always_ff @(posedge clk_i) begin
        for (int s = 0; s < NSLOT; s++) begin
            if (we_i[s] && !flush_i) begin
                mem_q[slot_idx[s]] <= wdata_i[s*ENT_W +: ENT_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else if (flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            wr_ptr_q <= wr_adv;
            if (pop_i) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
        end
    end

    assign rdata_o = mem_q[rd_ptr_q];

    p_distinct_slots_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i[0] && we_i[1]) |-> (slot_idx[0] != slot_idx[1]));
endmodule

// File: rtl/instr_queue_replay.sv
module instr_queue_replay
    import iq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 32,
    parameter int INSTR_W = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  flush_i,
    input  logic [1:0]            valid_i,
    input  logic [2*INSTR_W-1:0]  instr_i,
    input  logic [2*ADDR_W-1:0]   addr_i,
    input  logic [2*CF_W-1:0]     cf_type_i,
    input  logic [ADDR_W-1:0]     predict_addr_i,
    input  logic                  exception_i,
    input  logic [ADDR_W-1:0]     exception_addr_i,
    output logic                  ready_o,
    output logic [1:0]            consumed_o,
    output logic                  replay_o,
    output logic [ADDR_W-1:0]     replay_addr_o,
    output logic                  out_valid_o,
    input  logic                  out_ready_i,
    output logic [INSTR_W-1:0]    out_instr_o,
    output logic [ADDR_W-1:0]     out_addr_o,
    output logic [CF_W-1:0]       out_cf_o,
    output logic [ADDR_W-1:0]     out_pred_o,
    output logic                  out_ex_o,
    output logic [ADDR_W-1:0]     out_ex_addr_o
);
    localparam int NSLOT = 2;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ENT_W = 1 + 3 * ADDR_W + CF_W + INSTR_W;

    logic [NSLOT-1:0]       accept;
    logic [CNT_W-1:0]       free_cnt;
    logic [CNT_W-1:0]       push_cnt;
    logic                   occupied;
    logic                   pair_room;
    logic                   pop;
    fill_state_e            fill_state;
    logic [NSLOT*ENT_W-1:0] wdata;
    logic [ENT_W-1:0]       head;

    iq_slot_admit #(
        .NSLOT (NSLOT),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_admit (
        .flush_i      (flush_i),
        .valid_i      (valid_i),
        .addr_i       (addr_i),
        .free_i       (free_cnt),
        .accept_o     (accept),
        .replay_o     (replay_o),
        .replay_addr_o(replay_addr_o)
    );

    always_comb begin
        push_cnt = '0;
        for (int s = 0; s < NSLOT; s++) begin
            push_cnt = push_cnt + CNT_W'(accept[s]);
        end
    end

    iq_fill_ctrl #(
        .DEPTH(DEPTH),
        .NSLOT(NSLOT),
        .CNT_W(CNT_W)
    ) u_fill (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (flush_i),
        .push_cnt_i (push_cnt),
        .pop_i      (pop),
        .free_o     (free_cnt),
        .occupied_o (occupied),
        .pair_room_o(pair_room),
        .state_o    (fill_state)
    );

    // Entry packing: {fault, fault addr, prediction, kind, address, word}.
    for (genvar s = 0; s < NSLOT; s++) begin : g_pack
        assign wdata[s*ENT_W +: ENT_W] = {
            exception_i,
            exception_addr_i,
            predict_addr_i,
            cf_type_i[s*CF_W +: CF_W],
            addr_i[s*ADDR_W +: ADDR_W],
            instr_i[s*INSTR_W +: INSTR_W]
        };
    end

    iq_ring #(
        .DEPTH(DEPTH),
        .NSLOT(NSLOT),
        .ENT_W(ENT_W)
    ) u_ring (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .flush_i(flush_i),
        .we_i   (accept),
        .wdata_i(wdata),
        .pop_i  (pop),
        .rdata_o(head)
    );

    assign out_valid_o = occupied && !flush_i;
    assign pop         = out_valid_o && out_ready_i;
    assign ready_o     = pair_room;
    assign consumed_o  = accept;

    assign {out_ex_o, out_ex_addr_o, out_pred_o, out_cf_o, out_addr_o, out_instr_o} = head;

    p_ready_takes_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !flush_i) |-> (consumed_o == valid_i));

    p_replay_has_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        replay_o |-> ((valid_i & ~consumed_o) != 2'b00));

    p_consumed_subset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (consumed_o & ~valid_i) == 2'b00);

    p_slot_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (consumed_o[1] && valid_i[0]) |-> consumed_o[0]);

    p_flush_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> (consumed_o == 2'b00 && !replay_o && !out_valid_o));

    p_flush_then_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !out_valid_o);

    p_full_rejects_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_state == FILL_FULL) |-> (consumed_o == 2'b00));
endmodule

// File: tb/tb_instr_queue_replay.sv
module tb_instr_queue_replay;
    localparam logic [31:0] KEY = 32'h5A5A_0000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        flush_i = 1'b0;
    logic [1:0]  valid_i = 2'b00;
    logic [63:0] instr_i = '0;
    logic [63:0] addr_i = '0;
    logic [5:0]  cf_type_i = '0;
    logic [31:0] predict_addr_i = '0;
    logic        exception_i = 1'b0;
    logic [31:0] exception_addr_i = '0;
    logic        ready_o;
    logic [1:0]  consumed_o;
    logic        replay_o;
    logic [31:0] replay_addr_o;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic [31:0] out_instr_o;
    logic [31:0] out_addr_o;
    logic [2:0]  out_cf_o;
    logic [31:0] out_pred_o;
    logic        out_ex_o;
    logic [31:0] out_ex_addr_o;

    instr_queue_replay dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .valid_i(valid_i),
        .instr_i(instr_i), .addr_i(addr_i), .cf_type_i(cf_type_i),
        .predict_addr_i(predict_addr_i), .exception_i(exception_i),
        .exception_addr_i(exception_addr_i), .ready_o(ready_o),
        .consumed_o(consumed_o), .replay_o(replay_o), .replay_addr_o(replay_addr_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_instr_o(out_instr_o), .out_addr_o(out_addr_o), .out_cf_o(out_cf_o),
        .out_pred_o(out_pred_o), .out_ex_o(out_ex_o), .out_ex_addr_o(out_ex_addr_o)
    );

    always #2 clk_i = ~clk_i;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Vector: [9] flush [8:7] valid [6] decoder ready | [5:4] accept
    // [3] replay [2] replay slot [1] ready [0] head valid
    localparam int NVEC = 16;
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0_11_0_11_0_0_1_0,
        10'b0_01_0_01_0_0_1_1,
        10'b0_11_0_01_1_1_0_1,
        10'b0_11_1_00_1_0_0_1,
        10'b0_10_1_10_0_0_0_1,
        10'b0_00_1_00_0_0_0_1,
        10'b0_00_1_00_0_0_1_1,
        10'b0_11_1_11_0_0_1_1,
        10'b1_11_1_00_0_0_1_0,
        10'b0_00_1_00_0_0_1_0,
        10'b0_10_0_10_0_0_1_0,
        10'b0_11_0_11_0_0_1_1,
        10'b0_00_1_00_0_0_0_1,
        10'b0_00_1_00_0_0_1_1,
        10'b0_00_1_00_0_0_1_1,
        10'b0_00_0_00_0_0_1_0
    };

    logic [31:0] m_addr [32];
    logic [2:0]  m_cf   [32];
    logic [31:0] m_pred [32];
    logic        m_ex   [32];
    logic [31:0] m_exa  [32];
    int m_head = 0;
    int m_tail = 0;

    task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] a0_of(input int step);
        return 32'h1000 + 32'(step) * 32'd8;
    endfunction

    task automatic drive(input int step, input logic fl, input logic [1:0] v, input logic rdy);
        logic [31:0] a0, a1;
        a0 = a0_of(step);
        a1 = a0 + 32'd4;
        flush_i          = fl;
        valid_i          = v;
        out_ready_i      = rdy;
        addr_i           = {a1, a0};
        instr_i          = {a1 ^ KEY, a0 ^ KEY};
        cf_type_i        = {3'(((step + 1) % 5)), 3'((step % 5))};
        predict_addr_i   = 32'h8000_0000 | (32'(step) << 4);
        exception_i      = (step == 2 || step == 12);
        exception_addr_i = 32'hE000_0000 + 32'(step);
    endtask

    initial begin
        // R1: reset state
        drive(0, 1'b0, 2'b00, 1'b0);
        #1;
        chk("R1 out_valid in reset", out_valid_o == 1'b0, 64'(out_valid_o), 64'd0);
        chk("R1 ready in reset", ready_o == 1'b1, 64'(ready_o), 64'd1);
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        #1;
        chk("R1 idle after reset", {out_valid_o, ready_o, replay_o, consumed_o} == 5'b01000,
            64'({out_valid_o, ready_o, replay_o, consumed_o}), 64'b01000);

        for (int i = 0; i < NVEC; i++) begin
            logic [9:0] v;
            int step;
            v = VEC[i];
            step = i + 1;
            @(negedge clk_i);
            drive(step, v[9], v[8:7], v[6]);
            #1;
            chk(v[3] ? "R5 R6 consumed" : (v[9] ? "R8 consumed" : "R6 consumed"),
                consumed_o == v[5:4], 64'(consumed_o), 64'(v[5:4]));
            chk(v[9] ? "R8 replay" : "R5 replay", replay_o == v[3], 64'(replay_o), 64'(v[3]));
            if (v[3]) begin
                logic [31:0] ra;
                ra = a0_of(step) + (v[2] ? 32'd4 : 32'd0);
                chk("R5 replay address", replay_addr_o == ra, 64'(replay_addr_o), 64'(ra));
            end
            chk("R7 R9 ready", ready_o == v[1], 64'(ready_o), 64'(v[1]));
            chk(v[9] ? "R8 out_valid" : "R3 out_valid", out_valid_o == v[0], 64'(out_valid_o), 64'(v[0]));
            if (v[0] && out_valid_o) begin
                logic [31:0] ea;
                ea = m_addr[m_head];
                chk("R3 R4 R11 head addr", out_addr_o == ea, 64'(out_addr_o), 64'(ea));
                chk("R3 head instr", out_instr_o == (ea ^ KEY), 64'(out_instr_o), 64'(ea ^ KEY));
                chk("R3 head kind/pred", {out_cf_o, out_pred_o} == {m_cf[m_head], m_pred[m_head]},
                    64'({out_cf_o, out_pred_o}), 64'({m_cf[m_head], m_pred[m_head]}));
                chk("R10 head fault", {out_ex_o, out_ex_addr_o} == {m_ex[m_head], m_exa[m_head]},
                    64'({out_ex_o, out_ex_addr_o}), 64'({m_ex[m_head], m_exa[m_head]}));
            end
            // reference model update from the table
            if (v[9]) begin
                m_head = m_tail;
            end else begin
                if (v[0] && v[6]) m_head++;
                for (int s = 0; s < 2; s++) begin
                    if (v[4 + s]) begin
                        m_addr[m_tail] = addr_i[s*32 +: 32];
                        m_cf[m_tail]   = cf_type_i[s*3 +: 3];
                        m_pred[m_tail] = predict_addr_i;
                        m_ex[m_tail]   = exception_i;
                        m_exa[m_tail]  = exception_addr_i;
                        m_tail++;
                    end
                end
            end
        end

        // R9: two pushes with a pop leave three entries -> ready drops
        @(negedge clk_i);
        drive(40, 1'b0, 2'b11, 1'b0);
        @(negedge clk_i);
        drive(41, 1'b0, 2'b11, 1'b1);
        #1;
        chk("R9 push+pop accept", consumed_o == 2'b11, 64'(consumed_o), 64'b11);
        @(negedge clk_i);
        drive(42, 1'b0, 2'b00, 1'b0);
        #1;
        chk("R9 occupancy after push+pop", ready_o == 1'b0, 64'(ready_o), 64'd0);
        chk("R3 head after push+pop", out_addr_o == a0_of(40) + 32'd4, 64'(out_addr_o), 64'(a0_of(40) + 32'd4));

        // R1: reset with entries stored
        rst_ni = 1'b0;
        #1;
        chk("R1 reset clears", {out_valid_o, ready_o} == 2'b01, 64'({out_valid_o, ready_o}), 64'b01);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        #1;
        chk("R1 empty after reset", out_valid_o == 1'b0, 64'(out_valid_o), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule